// File: doc/BRIEF.md
# Nonlinear Scan Register Load and Readback Solver

This block works beside a fixed K-stage feed-forward scan register whose stages are scrambled by constant inversions and by AND-gated feed-forward terms. With these terms, neither the bits shifted in nor the bits shifted out match the stored state. The block solves the two problems a tester needs solved for such a chain. The first is load: given a target state, it computes the K serial bits that leave the register in that state, whatever the register held before. The second is readback: given the K bits applied and the K bits observed at the chain output, it recovers the state the register held before shifting began. Both answers come from plain implication, one stage per clock, with no search. Because load and readback each take K shifts, the next pattern's load and the previous response's readback can share the same K shift cycles.

The scrambled register is defined as follows, with stage 0 at the serial input and x as the serial bit. On each clock, stage 0 takes x XOR INV_MASK[0], stage 1 takes stage0 XOR INV_MASK[1] XOR (TAP_MASK[1] AND x), and stage j≥2 takes stage(j-1) XOR INV_MASK[j] XOR (TAP_MASK[j] AND x AND stage(j-2)). The serial output z is stage K-1 before the clock. Sequence ports hold bit t as the bit of shift t, so bit 0 is shifted first.

Top module: `scan_unscramble_solver`

## Requirements
- R1: After reset, busy and done are 0 and state_out and xseq_out are all zeros.
- R2: In load mode (mode=0), xseq_out applied to the register bit 0 first for K clocks leaves the register holding state_in.
- R3: The load sequence depends only on the requested state. The same xseq_out reaches the target from every one of the 2^K starting states.
- R4: A request for the all-ones state yields a sequence that reaches all-ones from every starting state.
- R5: In readback mode (mode=1), state_out equals the register's initial state, given xseq_in as the applied bits and zseq_in as the observed bits (bit t = z before shift t).
- R6: done is a one-cycle pulse that rises on the K-th rising clock edge after the edge that accepts start, and busy covers exactly the cycles between those two edges.
- R7: A start raised while busy is ignored. The running request completes with its own result.
- R8: state_out and xseq_out keep their values while the block is idle and no start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 1 | 0 = load solve, 1 = readback solve |
| state_in | input | K | Target state for load |
| xseq_in | input | K | Applied serial bits for readback |
| zseq_in | input | K | Observed serial bits for readback |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle completion pulse |
| state_out | output | K | Recovered initial state |
| xseq_out | output | K | Load sequence, bit 0 shifted first |

## Verification
The assertions assume that start is a synchronous level sampled at the clock and that the request inputs are meaningful only in the accept cycle. The assertions do not assume that start stays low while the block is busy. The stimulus drives every input on the falling edge and holds state_in, xseq_in and zseq_in only around the start pulse. It also raises start once in the middle of a solve with a different request, to exercise the ignore path. The register model in the bench uses the mask definitions stated above, so expected values never depend on the solver's own arithmetic.

// File: rtl/scan_unscramble_pkg.sv
package scan_unscramble_pkg;
   typedef enum logic {
      SOLVE_LOAD     = 1'b0,
      SOLVE_READBACK = 1'b1
   } solve_mode_e;
endpackage

// File: rtl/ssr_fwd_step.sv
module ssr_fwd_step #(
   parameter int K = 5,
   parameter logic [K-1:0] INV_MASK = '0,
   parameter logic [K-1:0] TAP_MASK = '0
) (
   input  logic [K-1:0] y,
   input  logic         x,
   output logic [K-1:0] y_nxt
);
   always_comb begin
      y_nxt[0] = x ^ INV_MASK[0];
      y_nxt[1] = y[0] ^ INV_MASK[1] ^ (TAP_MASK[1] & x);
      for (int j = 2; j < K; j++) begin
         y_nxt[j] = y[j-1] ^ INV_MASK[j] ^ (TAP_MASK[j] & x & y[j-2]);
      end
   end
endmodule

// File: rtl/ssr_bwd_step.sv
module ssr_bwd_step #(
   parameter int K = 5,
   parameter logic [K-1:0] INV_MASK = '0,
   parameter logic [K-1:0] TAP_MASK = '0
) (
   input  logic [K-1:0] v,
   output logic         x,
   output logic [K-1:0] v_prev
);
   always_comb begin
      x         = v[0] ^ INV_MASK[0];
      v_prev[0] = v[1] ^ INV_MASK[1] ^ (TAP_MASK[1] & x);
      for (int j = 2; j < K; j++) begin
         v_prev[j-1] = v[j] ^ INV_MASK[j] ^ (TAP_MASK[j] & x & v_prev[j-2]);
      end
      v_prev[K-1] = 1'b0;
   end
endmodule

// File: rtl/scan_unscramble_solver.sv
module scan_unscramble_solver
   import scan_unscramble_pkg::*;
#(
   parameter int K = 5,
   parameter logic [K-1:0] INV_MASK = 5'b01101,
   parameter logic [K-1:0] TAP_MASK = 5'b10110
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         mode,
   input  logic [K-1:0] state_in,
   input  logic [K-1:0] xseq_in,
   input  logic [K-1:0] zseq_in,
   output logic         busy,
   output logic         done,
   output logic [K-1:0] state_out,
   output logic [K-1:0] xseq_out
);
   localparam int CW = $clog2(K + 1);
   localparam logic [CW-1:0] LAST = CW'(K - 1);

   if (K < 3) begin : g_bad_k
      $error("scan_unscramble_solver: K must be at least 3");
   end
   if (TAP_MASK[0] != 1'b0) begin : g_bad_tap
      $error("scan_unscramble_solver: TAP_MASK[0] has no stage to feed");
   end

   solve_mode_e    mode_q;
   logic [CW-1:0]  cnt;
   logic [K-1:0]   work, work_nxt, xacc, xq, zq;
   logic           step_x;
   logic [K-1:0]   back_v;
   logic [K-1:0]   sim_st [K];
   logic [K-1:0]   zsim, diff_rev;
   logic           id_bit;

   ssr_bwd_step #(.K(K), .INV_MASK(INV_MASK), .TAP_MASK(TAP_MASK)) u_bwd (
      .v(work), .x(step_x), .v_prev(back_v)
   );

   assign sim_st[0] = work;
   for (genvar t = 0; t < K - 1; t++) begin : g_sim
      ssr_fwd_step #(.K(K), .INV_MASK(INV_MASK), .TAP_MASK(TAP_MASK)) u_fwd (
         .y(sim_st[t]), .x(xq[t]), .y_nxt(sim_st[t+1])
      );
   end
   for (genvar t = 0; t < K; t++) begin : g_obs
      assign zsim[t]         = sim_st[t][K-1];
      assign diff_rev[K-1-t] = zsim[t] ^ zq[t];
   end

   assign id_bit = diff_rev[cnt];

   always_comb begin
      if (mode_q == SOLVE_LOAD) work_nxt = back_v;
      else                      work_nxt = work | (K'(id_bit) << cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         cnt       <= '0;
         mode_q    <= SOLVE_LOAD;
         work      <= '0;
         xacc      <= '0;
         xq        <= '0;
         zq        <= '0;
         state_out <= '0;
         xseq_out  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               cnt    <= '0;
               mode_q <= solve_mode_e'(mode);
               work   <= (mode == SOLVE_READBACK) ? '0 : state_in;
               xq     <= xseq_in;
               zq     <= zseq_in;
               xacc   <= '0;
            end
         end else begin
            work <= work_nxt;
            xacc <= {xacc[K-2:0], step_x};
            cnt  <= cnt + 1'b1;
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
               if (mode_q == SOLVE_LOAD) xseq_out  <= {xacc[K-2:0], step_x};
               else                      state_out <= work_nxt;
            end
         end
      end
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy) && !busy);
   a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != LAST) |=> busy && !done);
   a_r7_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(state_out) && $stable(xseq_out));
endmodule

// File: tb/scan_unscramble_solver_tb.sv
module scan_unscramble_solver_tb;
   localparam int K = 5;
   localparam logic [K-1:0] INV = 5'b01101;
   localparam logic [K-1:0] TAP = 5'b10110;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
   logic [K-1:0] state_in = '0, xseq_in = '0, zseq_in = '0;
   logic busy, done;
   logic [K-1:0] state_out, xseq_out;
   int n_tests = 0, n_fail = 0, cyc = 0;

   scan_unscramble_solver #(.K(K), .INV_MASK(INV), .TAP_MASK(TAP)) u_dut (
      .clk, .rst_n, .start, .mode, .state_in, .xseq_in, .zseq_in,
      .busy, .done, .state_out, .xseq_out
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   function automatic logic [K-1:0] reg_step(logic [K-1:0] y, logic x);
      logic [K-1:0] n;
      n[0] = x ^ INV[0];
      n[1] = y[0] ^ INV[1] ^ (TAP[1] & x);
      for (int j = 2; j < K; j++) n[j] = y[j-1] ^ INV[j] ^ (TAP[j] & x & y[j-2]);
      return n;
   endfunction

   function automatic logic [K-1:0] shift_all(logic [K-1:0] y, logic [K-1:0] xs);
      for (int t = 0; t < K; t++) y = reg_step(y, xs[t]);
      return y;
   endfunction

   function automatic logic [K-1:0] observe(logic [K-1:0] y, logic [K-1:0] xs);
      logic [K-1:0] z;
      for (int t = 0; t < K; t++) begin
         z[t] = y[K-1];
         y = reg_step(y, xs[t]);
      end
      return z;
   endfunction

   task automatic check(string req, logic [K-1:0] act, logic [K-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic run(input logic m, input logic [K-1:0] s, xs, zs, output int lat);
      @(negedge clk);
      start = 1'b1; mode = m; state_in = s; xseq_in = xs; zseq_in = zs;
      @(negedge clk);
      start = 1'b0; state_in = '0; xseq_in = '0; zseq_in = '0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      logic [K-1:0] seq_a;
      #(CLK_PERIOD * 2.5);
      // R1: reset state
      check("R1 busy/done", {3'b0, busy, done}, '0);
      check("R1 state_out", state_out, '0);
      check("R1 xseq_out", xseq_out, '0);
      rst_n = 1'b1;

      // R2/R3: every target, every starting state
      for (int f = 0; f < (1 << K); f++) begin
         run(1'b0, K'(f), '0, '0, lat);
         check("R6 latency", K'(lat), K'(K));
         for (int s = 0; s < (1 << K); s++)
            check("R2 R3 load reaches target", shift_all(K'(s), xseq_out), K'(f));
      end

      // R4: all-ones target
      run(1'b0, '1, '0, '0, lat);
      for (int s = 0; s < (1 << K); s++)
         check("R4 all-ones from any state", shift_all(K'(s), xseq_out), '1);

      // R5: every hidden state under every applied sequence
      for (int s = 0; s < (1 << K); s++)
         for (int xs = 0; xs < (1 << K); xs++) begin
            run(1'b1, '0, K'(xs), observe(K'(s), K'(xs)), lat);
            check("R5 readback state", state_out, K'(s));
         end

      // R6: done pulse width
      @(negedge clk);
      check("R6 done one cycle", {4'b0, done}, '0);

      // R7: start during busy is ignored
      @(negedge clk);
      start = 1'b1; mode = 1'b0; state_in = 5'b10011;
      @(negedge clk);
      start = 1'b1; mode = 1'b1; state_in = 5'b01100;
      xseq_in = 5'b11111; zseq_in = 5'b10101;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      check("R7 busy start ignored", shift_all(5'b00000, xseq_out), 5'b10011);
      check("R7 readback result kept", state_out, 5'd31);
      seq_a = xseq_out;

      // R8: hold while idle
      repeat (6) @(negedge clk);
      check("R8 xseq_out held", xseq_out, seq_a);
      check("R8 state_out held", state_out, 5'd31);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule